// File: doc/BRIEF.md
# Add-Immediate Execute Unit with Carry Control

This unit executes one 32-bit add-immediate instruction family inside a single-issue datapath. Each cycle it may receive an instruction word, the value already read for the source register, and the current status carry bit. From these it produces the destination index, the write-back value, a write enable and the carry bit to be stored next. Write-back and the next carry bit are combinational, so the surrounding pipeline decides when to latch them.

Two opcode bits act independently. One selects whether the status carry is added in. The other selects whether the carry flag is preserved or reloaded from the carry-out of the add. The 16-bit immediate is normally sign-extended. A preceding prefix can instead supply the upper half: the unit latches that half with a pending flag, and the next valid instruction consumes it as a full 32-bit operand.

Top module: `addimm_exec`

## Requirements
- R1: After reset, `imm_pending` is 0. With `instr_valid` low, `rd_we` is 0 and `carry_next` equals `msr_c`.
- R2: Instruction bits use LSB-0 numbering. Bits [31:26] hold the opcode 0,0,1,K,C,0, with K at bit 28 and C at bit 27. The destination index is in bits [25:21] and is driven on `rd_idx`. The 16-bit immediate is in bits [15:0].
- R3: With no prefix pending, the operand is the immediate sign-extended to 32 bits.
- R4: With C=1 (bit 27), `rd_data` = ra_val + operand + msr_c, modulo 2^32. With C=0, `rd_data` = ra_val + operand, whatever `msr_c` is.
- R5: With K=1 (bit 28), `carry_next` equals `msr_c`. With K=0, `carry_next` is bit 32 of the 33-bit sum ra_val + operand + carry-in.
- R6: A cycle with `pfx_load` high sets `imm_pending` and stores `pfx_data` from the next clock edge. While pending, the operand is {stored half, imm16}.
- R7: A valid instruction consumes the pending prefix, which clears `imm_pending` at the next edge. If `pfx_load` is high in the same cycle, that instruction still uses the old prefix state, and the new half stays pending for the following instruction.
- R8: `rd_we` is high only when `instr_valid` is high, the opcode matches 001xx0 and the destination index is nonzero.
- R9: A valid instruction whose opcode does not match 001xx0 gives `rd_we` = 0 and `carry_next` = `msr_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| ra_val | input | 32 | Source register value |
| msr_c | input | 1 | Current status carry bit |
| pfx_load | input | 1 | Latch a prefix upper half |
| pfx_data | input | 16 | Upper half to latch |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Write-back value |
| rd_we | output | 1 | Destination write enable |
| carry_next | output | 1 | Carry bit to store |
| imm_pending | output | 1 | A prefix half is waiting to be consumed |

## Verification
A prefix load and the consumption of an earlier prefix can occur in the same cycle. The bench provokes this by loading one upper half and then, in a single cycle, issuing an instruction while loading a second half. That instruction must add using the first half. The next instruction must use the second half, and a third instruction must fall back to sign extension, which shows the second half was consumed exactly once.

// File: rtl/addimm_exec.sv
module addimm_exec #(
  parameter int XLEN = 32,
  parameter int HLEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] ra_val,
  input  logic            msr_c,
  input  logic            pfx_load,
  input  logic [HLEN-1:0] pfx_data,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_we,
  output logic            carry_next,
  output logic            imm_pending
);
  logic [HLEN-1:0] hi_q;
  logic            match, op_k, op_c, cin;
  logic [XLEN-1:0] operand;
  logic [XLEN:0]   sum;

  assign match  = (instr[31:29] == 3'b001) && !instr[26];
  assign op_k   = instr[28];
  assign op_c   = instr[27];
  assign rd_idx = instr[25:21];

  assign operand = imm_pending ? {hi_q, instr[15:0]}
                               : {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign cin     = op_c & msr_c;
  assign sum     = {1'b0, ra_val} + {1'b0, operand} + {{XLEN{1'b0}}, cin};

  assign rd_data    = sum[XLEN-1:0];
  assign rd_we      = instr_valid && match && (rd_idx != 5'd0);
  assign carry_next = (instr_valid && match && !op_k) ? sum[XLEN] : msr_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_pending <= 1'b0;
      hi_q        <= '0;
    end else if (pfx_load) begin
      imm_pending <= 1'b1;
      hi_q        <= pfx_data;
    end else if (instr_valid) begin
      imm_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/addimm_exec_chk.sv
module addimm_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [31:0] instr,
  input logic        msr_c,
  input logic        pfx_load,
  input logic [4:0]  rd_idx,
  input logic        rd_we,
  input logic        carry_next,
  input logic        imm_pending
);
  logic opm;
  assign opm = (instr[31:29] == 3'b001) && !instr[26];

  assert_we_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (instr_valid && opm && rd_idx != 5'd0));

  assert_keep_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opm && instr[28]) |-> (carry_next == msr_c));

  assert_nomatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !opm) |-> (!rd_we && carry_next == msr_c));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!rd_we && carry_next == msr_c));

  assert_pfx_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_load |=> imm_pending);

  assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !pfx_load) |=> !imm_pending);
endmodule

bind addimm_exec addimm_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .msr_c(msr_c), .pfx_load(pfx_load), .rd_idx(rd_idx), .rd_we(rd_we),
  .carry_next(carry_next), .imm_pending(imm_pending)
);

// File: tb/addimm_exec_tb.sv
module addimm_exec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] ra_val = '0;
  logic        msr_c = 1'b0;
  logic        pfx_load = 1'b0;
  logic [15:0] pfx_data = '0;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        rd_we;
  logic        carry_next;
  logic        imm_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addimm_exec u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ra_val(ra_val), .msr_c(msr_c), .pfx_load(pfx_load), .pfx_data(pfx_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_we(rd_we),
    .carry_next(carry_next), .imm_pending(imm_pending)
  );

  function automatic logic [31:0] mk(input bit k, input bit c, input logic [4:0] rd,
                                     input logic [4:0] ra, input logic [15:0] imm);
    return {3'b001, k, c, 1'b0, rd, ra, imm};
  endfunction

  function automatic logic [32:0] ref_sum(input logic [31:0] a, input logic [31:0] op,
                                          input bit cin);
    return {1'b0, a} + {1'b0, op} + {32'd0, cin};
  endfunction

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [31:0] ins, input logic [31:0] a,
                       input bit c, input bit pl, input logic [15:0] pd);
    @(negedge clk);
    instr_valid = v; instr = ins; ra_val = a; msr_c = c; pfx_load = pl; pfx_data = pd;
    #1;
  endtask

  task automatic expect_add(input string req, input bit k, input bit c, input bit cf,
                            input logic [31:0] a, input logic [31:0] op,
                            input logic [4:0] rd);
    logic [32:0] s;
    s = ref_sum(a, op, c & cf);
    chk(req, {1'b0, rd_data}, {1'b0, s[31:0]});
    chk(req, {32'd0, carry_next}, {32'd0, (k ? cf : s[32])});
    chk("R8", {32'd0, rd_we}, {32'd0, (rd != 5'd0)});
    chk("R2", {28'd0, rd_idx}, {28'd0, rd});
  endtask

  task automatic t_reset();
    drive(1'b0, '0, '0, 1'b1, 1'b0, '0);
    chk("R1 pending", {32'd0, imm_pending}, 33'd0);
    chk("R1 we", {32'd0, rd_we}, 33'd0);
    chk("R1 carry", {32'd0, carry_next}, 33'd1);
  endtask

  task automatic t_kc_matrix();
    for (int i = 0; i < 8; i++) begin
      bit k, c, cf;
      logic [31:0] a;
      k = i[2]; c = i[1]; cf = i[0];
      a = 32'hFFFF_FFF0;
      drive(1'b1, mk(k, c, 5'd3, 5'd1, 16'h000F), a, cf, 1'b0, '0);
      expect_add("R4 R5 matrix", k, c, cf, a, 32'h0000_000F, 5'd3);
    end
  endtask

  task automatic t_overflow();
    drive(1'b1, mk(1'b0, 1'b0, 5'd7, 5'd2, 16'h0001), 32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    expect_add("R5 overflow", 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1, 5'd7);
    chk("R5 wrap", {1'b0, rd_data}, 33'd0);
    drive(1'b1, mk(1'b0, 1'b1, 5'd7, 5'd2, 16'h0000), 32'hFFFF_FFFF, 1'b1, 1'b0, '0);
    chk("R4 cin wrap", {carry_next, rd_data}, {1'b1, 32'd0});
    drive(1'b1, mk(1'b0, 1'b0, 5'd7, 5'd2, 16'h0000), 32'hFFFF_FFFF, 1'b1, 1'b0, '0);
    chk("R4 C=0 ignores flag", {carry_next, rd_data}, {1'b0, 32'hFFFF_FFFF});
  endtask

  task automatic t_neg_imm();
    drive(1'b1, mk(1'b0, 1'b0, 5'd9, 5'd4, 16'hFFFE), 32'd5, 1'b0, 1'b0, '0);
    expect_add("R3 sext", 1'b0, 1'b0, 1'b0, 32'd5, 32'hFFFF_FFFE, 5'd9);
    chk("R3 value", {1'b0, rd_data}, 33'd3);
  endtask

  task automatic t_prefix();
    drive(1'b0, '0, '0, 1'b0, 1'b1, 16'h1234);
    drive(1'b0, '0, '0, 1'b0, 1'b0, '0);
    chk("R6 pending", {32'd0, imm_pending}, 33'd1);
    drive(1'b1, mk(1'b0, 1'b0, 5'd9, 5'd4, 16'hFFFE), 32'd5, 1'b0, 1'b0, '0);
    expect_add("R6 prefixed", 1'b0, 1'b0, 1'b0, 32'd5, 32'h1234_FFFE, 5'd9);
    drive(1'b0, '0, '0, 1'b0, 1'b0, '0);
    chk("R7 consumed", {32'd0, imm_pending}, 33'd0);
  endtask

  task automatic t_collide();
    drive(1'b0, '0, '0, 1'b0, 1'b1, 16'hA000);
    drive(1'b1, mk(1'b0, 1'b0, 5'd1, 5'd1, 16'h8001), 32'd0, 1'b0, 1'b1, 16'h0055);
    expect_add("R7 old prefix", 1'b0, 1'b0, 1'b0, 32'd0, 32'hA000_8001, 5'd1);
    drive(1'b1, mk(1'b0, 1'b0, 5'd1, 5'd1, 16'h8001), 32'd0, 1'b0, 1'b0, '0);
    chk("R7 pending kept", {32'd0, imm_pending}, 33'd1);
    expect_add("R7 new prefix", 1'b0, 1'b0, 1'b0, 32'd0, 32'h0055_8001, 5'd1);
    drive(1'b1, mk(1'b0, 1'b0, 5'd1, 5'd1, 16'h8001), 32'd0, 1'b0, 1'b0, '0);
    expect_add("R7 back to sext", 1'b0, 1'b0, 1'b0, 32'd0, 32'hFFFF_8001, 5'd1);
  endtask

  task automatic t_nomatch();
    logic [31:0] bad;
    bad = mk(1'b0, 1'b0, 5'd6, 5'd1, 16'h0001);
    bad[26] = 1'b1;
    drive(1'b1, bad, 32'hFFFF_FFFF, 1'b1, 1'b0, '0);
    chk("R9 we", {32'd0, rd_we}, 33'd0);
    chk("R9 carry", {32'd0, carry_next}, 33'd1);
    bad = mk(1'b0, 1'b0, 5'd6, 5'd1, 16'h0001);
    bad[31] = 1'b1;
    drive(1'b1, bad, 32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    chk("R9 we2", {32'd0, rd_we}, 33'd0);
    chk("R9 carry2", {32'd0, carry_next}, 33'd0);
  endtask

  task automatic t_rd0();
    drive(1'b1, mk(1'b0, 1'b0, 5'd0, 5'd1, 16'h0001), 32'd1, 1'b0, 1'b0, '0);
    chk("R8 rd0", {32'd0, rd_we}, 33'd0);
    drive(1'b0, mk(1'b0, 1'b0, 5'd4, 5'd1, 16'h0001), 32'd1, 1'b0, 1'b0, '0);
    chk("R8 not valid", {32'd0, rd_we}, 33'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_kc_matrix();
    t_overflow();
    t_neg_imm();
    t_prefix();
    t_collide();
    t_nomatch();
    t_rd0();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule